// File: doc/BRIEF.md
# Banked Register File with Stack

This block is the 128-byte internal data store of a small 8-bit processor core. The bottom 32 bytes hold four banks of eight working registers. A two-bit bank select chooses the bank that a 3-bit register number refers to, so a context switch only has to change the bank select and copies no data. The same bytes can also be reached through a flat direct port that takes a 7-bit address. The full 00h–7Fh range is open to both the direct port and the stack.

A hardware stack grows upward through an 8-bit stack pointer. On a push the pointer is incremented first and the byte is written at the new address, so the pointer always names the last byte stored. On a pop the byte at the pointer is presented and the pointer then steps down. After reset the pointer holds 07h, so the first push lands at 08h, on top of bank 1. Software may reload the pointer at any time. A push that would carry the pointer beyond the last byte is refused and raises a sticky overflow flag.

All three read ports are combinational from the stored bytes. Writes take effect at the rising clock edge.

Top module: `bank_stack_ram`

## Requirements
- R1: An active-low asynchronous reset sets the stack pointer to 07h, clears the overflow flag and sets every byte to 00h.
- R2: The register port addresses byte bank*8+idx, where bank is bank_sel (00, 01, 10, 11 give base 00h, 08h, 10h, 18h) and idx is reg_idx. Reads and writes both use this mapping.
- R3: The direct port reads and writes the byte at dir_addr, anywhere in 00h–7Fh.
- R4: A push with the pointer below 7Fh increments the pointer and writes push_data at the new pointer value. Starting from 07h, pushing 25h, 12h and F3h fills 08h, 09h and 0Ah and leaves the pointer at 0Ah.
- R5: During a pop, stk_rdata shows the byte at the current pointer, and the pointer is one lower after the clock edge.
- R6: An asserted sp_load places sp_wdata in the pointer and clears the overflow flag. It overrides a push or pop in the same cycle, which then has no effect. After a load of 5Fh, the next push stores at 60h.
- R7: A push with the pointer at 7Fh or above writes nothing, leaves the pointer unchanged and sets ovf. ovf then stays set until the next pointer load or reset.
- R8: When writes from several ports target the same byte in one cycle, the push wins over the register port, and the register port wins over the direct port.
- R9: When push and pop are asserted together without a load, only the push acts.
- R10: A write becomes visible on the read ports in the cycle after its clock edge. A read of the byte being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 2 | Bank select for the register port |
| reg_idx | input | 3 | Register number within the selected bank |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Byte at the mapped register address |
| dir_addr | input | 7 | Direct port byte address |
| dir_we | input | 1 | Direct port write enable |
| dir_wdata | input | 8 | Direct port write data |
| dir_rdata | output | 8 | Byte at dir_addr |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| stk_rdata | output | 8 | Byte at the stack pointer (00h when the pointer is above 7Fh) |
| sp_load | input | 1 | Stack pointer load strobe |
| sp_wdata | input | 8 | Value for a pointer load |
| sp | output | 8 | Current stack pointer |
| ovf | output | 1 | Sticky stack overflow flag |

## Verification
The properties assume that the strobes and push_data are known and held steady across each rising edge. They also assume that reset is applied before the first checked edge. The stimulus meets both conditions: it changes every input only on the falling edge and returns all strobes to zero between operations. It also loads the pointer only with values up to 7Fh, so a pop never has to read through an out-of-range pointer. Under these conditions the properties follow the pointer one step per accepted push or pop, and they check that a refused push freezes the pointer while the overflow flag latches.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Base address of a bank, given the number of registers per bank.
  function automatic int unsigned bank_base(input int unsigned bank,
                                            input int unsigned regs_per_bank);
    return bank * regs_per_bank;
  endfunction

  // A push is allowed only while the pointer is below the top byte.
  function automatic bit push_room(input int unsigned ptr,
                                   input int unsigned top);
    return ptr < top;
  endfunction

  // A pointer value lies inside the data store.
  function automatic bit ptr_in_range(input int unsigned ptr,
                                      input int unsigned depth);
    return ptr < depth;
  endfunction

endpackage

// File: rtl/bsr_addr_map.sv
module bsr_addr_map #(
  parameter int IDX_W  = 3,
  parameter int BSEL_W = 2,
  parameter int AW     = 7
) (
  input  logic [BSEL_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [AW-1:0]     addr
);
  localparam int unsigned REGS = 1 << IDX_W;

  always_comb begin
    addr = AW'(bsr_pkg::bank_base(32'(bank), REGS) + 32'(idx));
  end
endmodule

// File: rtl/bsr_stack_ctl.sv
module bsr_stack_ctl #(
  parameter int SPW = 8,
  parameter int AW  = 7,
  parameter logic [SPW-1:0] SP_RST = 'h07
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic           sp_load,
  input  logic [SPW-1:0] sp_wdata,
  output logic [SPW-1:0] sp_q,
  output logic           ovf_q,
  output logic           push_fire,
  output logic           push_blocked,
  output logic           pop_fire,
  output logic [AW-1:0]  push_addr
);
  localparam int unsigned TOP = (1 << AW) - 1;

  logic           room;
  logic [SPW-1:0] sp_inc;

  always_comb begin
    room         = bsr_pkg::push_room(32'(sp_q), TOP);
    sp_inc       = sp_q + SPW'(1);
    push_fire    = push & ~sp_load & room;
    push_blocked = push & ~sp_load & ~room;
    pop_fire     = pop & ~push & ~sp_load;
    push_addr    = sp_inc[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_RST;
      ovf_q <= 1'b0;
    end else if (sp_load) begin
      sp_q  <= sp_wdata;
      ovf_q <= 1'b0;
    end else if (push_fire) begin
      sp_q <= sp_inc;
    end else if (push_blocked) begin
      ovf_q <= 1'b1;
    end else if (pop_fire) begin
      sp_q <= sp_q - SPW'(1);
    end
  end
endmodule

// File: rtl/bsr_mem_array.sv
module bsr_mem_array #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_we,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          dir_we,
  input  logic [AW-1:0] dir_addr,
  input  logic [DW-1:0] dir_wdata,
  input  logic          stk_valid,
  input  logic [AW-1:0] stk_addr,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] dir_rdata,
  output logic [DW-1:0] stk_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Later assignments win: direct < register < push.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (dir_we)  mem[dir_addr]  <= dir_wdata;
      if (reg_we)  mem[reg_addr]  <= reg_wdata;
      if (push_we) mem[push_addr] <= push_data;
    end
  end

  always_comb begin
    reg_rdata = mem[reg_addr];
    dir_rdata = mem[dir_addr];
    stk_rdata = stk_valid ? mem[stk_addr] : '0;
  end
endmodule

// File: rtl/bank_stack_ram.sv
module bank_stack_ram #(
  parameter int DW     = 8,
  parameter int AW     = 7,
  parameter int IDX_W  = 3,
  parameter int BSEL_W = 2,
  parameter int SPW    = 8,
  parameter logic [SPW-1:0] SP_RST = 'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSEL_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [AW-1:0]     dir_addr,
  input  logic              dir_we,
  input  logic [DW-1:0]     dir_wdata,
  output logic [DW-1:0]     dir_rdata,
  input  logic              push,
  input  logic              pop,
  input  logic [DW-1:0]     push_data,
  output logic [DW-1:0]     stk_rdata,
  input  logic              sp_load,
  input  logic [SPW-1:0]    sp_wdata,
  output logic [SPW-1:0]    sp,
  output logic              ovf
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [AW-1:0] reg_addr_w;
  logic [AW-1:0] push_addr;
  logic          push_fire;
  logic          push_blocked;
  logic          pop_fire;
  logic          stk_valid;

  bsr_addr_map #(.IDX_W(IDX_W), .BSEL_W(BSEL_W), .AW(AW)) u_map (
    .bank (bank_sel),
    .idx  (reg_idx),
    .addr (reg_addr_w)
  );

  bsr_stack_ctl #(.SPW(SPW), .AW(AW), .SP_RST(SP_RST)) u_stk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (push),
    .pop          (pop),
    .sp_load      (sp_load),
    .sp_wdata     (sp_wdata),
    .sp_q         (sp),
    .ovf_q        (ovf),
    .push_fire    (push_fire),
    .push_blocked (push_blocked),
    .pop_fire     (pop_fire),
    .push_addr    (push_addr)
  );

  always_comb stk_valid = bsr_pkg::ptr_in_range(32'(sp), DEPTH);

  bsr_mem_array #(.DW(DW), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_we   (push_fire),
    .push_addr (push_addr),
    .push_data (push_data),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr_w),
    .reg_wdata (reg_wdata),
    .dir_we    (dir_we),
    .dir_addr  (dir_addr),
    .dir_wdata (dir_wdata),
    .stk_valid (stk_valid),
    .stk_addr  (sp[AW-1:0]),
    .reg_rdata (reg_rdata),
    .dir_rdata (dir_rdata),
    .stk_rdata (stk_rdata)
  );
endmodule

// File: rtl/bank_stack_ram_chk.sv
module bank_stack_ram_chk #(
  parameter int DW  = 8,
  parameter int AW  = 7,
  parameter int SPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           push,
  input logic           pop,
  input logic [DW-1:0]  push_data,
  input logic           sp_load,
  input logic [SPW-1:0] sp_wdata,
  input logic [SPW-1:0] sp,
  input logic           ovf,
  input logic [DW-1:0]  stk_rdata,
  input logic           push_fire,
  input logic           push_blocked,
  input logic           pop_fire
);
  localparam logic [SPW-1:0] TOP = SPW'((1 << AW) - 1);

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp == $past(sp) + SPW'(1));

  p_push_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> stk_rdata == $past(push_data));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp == $past(sp) - SPW'(1));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (sp == $past(sp_wdata)) && !ovf);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sp_load && sp >= TOP) |=> ovf && (sp == $past(sp)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sp_load) |=> ovf);

  p_push_over_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !sp_load && sp < TOP) |=> sp == $past(sp) + SPW'(1));

  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_fire, push_blocked, pop_fire}));
endmodule

bind bank_stack_ram bank_stack_ram_chk #(.DW(DW), .AW(AW), .SPW(SPW)) u_chk (.*);

// File: tb/bank_stack_ram_bench.sv
module bank_stack_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic [2:0] reg_idx = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] dir_addr = '0;
  logic       dir_we = 1'b0;
  logic [7:0] dir_wdata = '0;
  logic [7:0] dir_rdata;
  logic       push = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] stk_rdata;
  logic       sp_load = 1'b0;
  logic [7:0] sp_wdata = '0;
  logic [7:0] sp;
  logic       ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_stack_ram u_bank_stack_ram (.*);

  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_LOAD = 3'd2,
                         OP_RWR = 3'd3, OP_RRD = 3'd4, OP_DWR = 3'd5,
                         OP_DRD = 3'd6, OP_SPCHK = 3'd7;
  // {op, a, b}: a = address, or {000, bank, idx}; b = data or expected value.
  localparam int NV = 24;
  localparam logic [18:0] VEC [NV] = '{
    {OP_SPCHK, 8'h00, 8'h07},
    {OP_PUSH,  8'h00, 8'h25},
    {OP_PUSH,  8'h00, 8'h12},
    {OP_PUSH,  8'h00, 8'hF3},
    {OP_SPCHK, 8'h00, 8'h0A},
    {OP_DRD,   8'h08, 8'h25},
    {OP_DRD,   8'h09, 8'h12},
    {OP_DRD,   8'h0A, 8'hF3},
    {OP_RRD,   8'h0A, 8'hF3},
    {OP_POP,   8'h00, 8'hF3},
    {OP_POP,   8'h00, 8'h12},
    {OP_SPCHK, 8'h00, 8'h08},
    {OP_RWR,   8'h1F, 8'h5A},
    {OP_DRD,   8'h1F, 8'h5A},
    {OP_DWR,   8'h13, 8'hC4},
    {OP_RRD,   8'h13, 8'hC4},
    {OP_RWR,   8'h00, 8'h77},
    {OP_DRD,   8'h00, 8'h77},
    {OP_LOAD,  8'h00, 8'h5F},
    {OP_PUSH,  8'h00, 8'h9E},
    {OP_DRD,   8'h60, 8'h9E},
    {OP_SPCHK, 8'h00, 8'h60},
    {OP_POP,   8'h00, 8'h9E},
    {OP_SPCHK, 8'h00, 8'h5F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; dir_we = 0; push = 0; pop = 0; sp_load = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sp", sp, 8'h07);
    chk("R1 ovf", {7'd0, ovf}, 8'h00);
    dir_addr = 7'h08; #1 chk("R1 byte", dir_rdata, 8'h00);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [2:0] op;
      logic [7:0] a, b;
      {op, a, b} = VEC[k];
      @(negedge clk);
      idle();
      bank_sel = a[4:3]; reg_idx = a[2:0]; dir_addr = a[6:0];
      case (op)
        OP_PUSH: begin push = 1; push_data = b; end
        OP_POP:  pop = 1;
        OP_LOAD: begin sp_load = 1; sp_wdata = b; end
        OP_RWR:  begin reg_we = 1; reg_wdata = b; end
        OP_DWR:  begin dir_we = 1; dir_wdata = b; end
        default: ;
      endcase
      #2;
      case (op)
        OP_POP:   chk("R5 pop data", stk_rdata, b);
        OP_RRD:   chk("R2 bank read", reg_rdata, b);
        OP_DRD:   chk("R3 direct read", dir_rdata, b);
        OP_SPCHK: chk("R4 R6 pointer", sp, b);
        default: ;
      endcase
    end

    // R7: overflow at the top byte
    @(negedge clk); idle(); sp_load = 1; sp_wdata = 8'h7E;
    @(negedge clk); idle(); push = 1; push_data = 8'h11;
    @(negedge clk); idle(); chk("R7 sp at top", sp, 8'h7F);
    push = 1; push_data = 8'h22;
    @(negedge clk); idle(); dir_addr = 7'h7F; #1;
    chk("R7 ovf set", {7'd0, ovf}, 8'h01);
    chk("R7 sp held", sp, 8'h7F);
    chk("R7 no write", dir_rdata, 8'h11);
    pop = 1; #1 chk("R7 R5 pop top", stk_rdata, 8'h11);
    @(negedge clk); idle();
    chk("R7 ovf sticky", {7'd0, ovf}, 8'h01);
    sp_load = 1; sp_wdata = 8'h0F;
    @(negedge clk); idle();
    chk("R7 R6 ovf cleared", {7'd0, ovf}, 8'h00);

    // R8: same-address write priority
    push = 1; push_data = 8'hAA;
    reg_we = 1; bank_sel = 2'b10; reg_idx = 3'd0; reg_wdata = 8'hBB;
    dir_we = 1; dir_addr = 7'h10; dir_wdata = 8'hCC;
    @(negedge clk); idle(); #1;
    chk("R8 push wins", dir_rdata, 8'hAA);
    reg_we = 1; reg_idx = 3'd1; reg_wdata = 8'hBB;
    dir_we = 1; dir_addr = 7'h11; dir_wdata = 8'hCC;
    @(negedge clk); idle(); #1;
    chk("R8 register wins", dir_rdata, 8'hBB);

    // R9: push and pop together
    push = 1; pop = 1; push_data = 8'h44;
    @(negedge clk); idle(); #1;
    chk("R9 sp", sp, 8'h11);
    chk("R9 data", stk_rdata, 8'h44);

    // R6: load overrides push
    sp_load = 1; sp_wdata = 8'h30; push = 1; push_data = 8'h55;
    @(negedge clk); idle(); dir_addr = 7'h31; #1;
    chk("R6 load wins sp", sp, 8'h30);
    chk("R6 push dropped", dir_rdata, 8'h00);

    // R10: same-cycle read returns old byte
    dir_we = 1; dir_addr = 7'h40; dir_wdata = 8'h66; #1;
    chk("R10 old value", dir_rdata, 8'h00);
    @(negedge clk); idle(); #1;
    chk("R10 new value", dir_rdata, 8'h66);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk); bank_sel = 2'b01; reg_idx = 3'd2; #1;
    chk("R1 sp after reset", sp, 8'h07);
    chk("R1 byte cleared", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule